// File: doc/BRIEF.md
# Two-Line Burst Byte Receiver

This block is the host end of a fast, single-device transfer over a pair of open-collector lines called DATA and CLOCK. A device signals that it is ready by pulling DATA low. The receiver answers with a four-step handshake on CLOCK. It then waits for a short pulse in which both lines fall and rise in the same cycle, and takes that rising edge as its only timing reference. From then on the device drives both lines. The receiver never drives them again. It reads two bits per sample on a fixed cycle schedule with no pacing signal, so the schedule must match the sender's instruction timing exactly.

Each byte takes four samples. Sample pairs are shifted in from the top, which leaves the first pair in the lowest bits. The receiver then reorders the byte from the sender's odd-then-even pair order into natural bit order. It presents the byte with a one-cycle strobe and a running index. After the fourth sample the receiver waits a fixed storage gap, which matches the time the sender spends fetching its next byte. After the requested number of bytes it returns to idle and waits for a new ready signal. If the sync pulse does not arrive in time, it flags an error and returns to idle.

Both line inputs are taken to be synchronous to `clk` already. A line input reads 1 when the line is released (high) and 0 when some device pulls it low.

Top module: `twobit_rx`

## Requirements
- R1: In idle, `clk_pull` is 0. In the first clock cycle after an edge that samples `data_in` at 0, `clk_pull` is 1.
- R2: `clk_pull` stays 1 for as long as `data_in` reads 0. It returns to 0 in the cycle after the first edge that samples `data_in` at 1.
- R3: After releasing CLOCK, the receiver waits for an edge where both lines read 0, then for an edge where both lines read 1. That second edge is the reference edge E0. A single line going low by itself is not a sync pulse. Once CLOCK has been released, `clk_pull` stays 0 until the transfer ends.
- R4: For each byte, the lines are sampled at four edges spaced `PAIR_GAP` (8) cycles apart. The first sample of the first byte is taken at edge E0 + `FIRST_OFS`.
- R5: Each sample forms a 2-bit pair, with DATA as the upper bit and CLOCK as the lower bit. The device sends pairs in this order: {b3,b1}, {b2,b0}, {b7,b5}, {b6,b4}. `rx_byte` gives back the natural byte b.
- R6: The first sample of the next byte comes `BYTE_GAP` (22) cycles after the fourth sample of the previous byte.
- R7: `rx_valid` is 1 for exactly the one cycle that follows the fourth-sample edge. During that cycle `rx_index` gives the byte's position in the transfer, counting from 0.
- R8: `byte_total` is read at E0, and a value of 0 counts as 1. After that many bytes, the receiver is idle in the cycle that carries the last strobe. It answers a new ready signal starting at the very next edge.
- R9: Count the cycles from the edge that releases CLOCK. If no reference edge has been seen within `SYNC_TIMEOUT` cycles, `sync_err` is 1 for exactly the cycle after edge (release + `SYNC_TIMEOUT`), and the receiver is idle in that same cycle.
- R10: `busy` is 1 from the acknowledge until the receiver returns to idle, and 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per sender instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | DATA line level (1 = released) |
| clk_in | input | 1 | CLOCK line level (1 = released) |
| byte_total | input | CNT_W | Number of bytes in the transfer (0 means 1) |
| clk_pull | output | 1 | 1 = pull the CLOCK line low |
| busy | output | 1 | Transfer in progress |
| rx_byte | output | 8 | Received byte in natural bit order |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_index | output | CNT_W | Position of the strobed byte in the transfer |
| sync_err | output | 1 | One-cycle pulse when the sync pulse does not arrive in time |

## Verification
The end of the last byte can land in the same cycle as the start of the next transfer. The fourth-sample edge raises the final strobe and sends the receiver to idle. The device may already be holding DATA low at the edge right after that one. The bench provokes this case by pulling DATA low in the half cycle that follows the last sample. It then expects three things: the correct byte and index in the strobe cycle, `busy` low in that same cycle, and `clk_pull` high exactly one cycle later, followed by a normal handshake and a correct second transfer.

// File: rtl/tbrx_pkg.sv
package tbrx_pkg;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_ACK,
        HS_WAIT_LO,
        HS_WAIT_HI,
        HS_RECV
    } hs_state_t;

    // One sample of the two lines: DATA is the upper bit, CLOCK the lower.
    typedef struct packed {
        logic hi;
        logic lo;
    } line_pair_t;

    localparam int PAIRS_PER_BYTE = 4;
    localparam int PAIR_IDX_W     = 2;

    // The raw byte holds pair k in bits 2k+1:2k. The pairs arrive as
    // {b3,b1},{b2,b0},{b7,b5},{b6,b4}; map them back to natural order.
    function automatic logic [7:0] unshuffle(input logic [7:0] raw);
        return {raw[5], raw[7], raw[4], raw[6], raw[1], raw[3], raw[0], raw[2]};
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tbrx_handshake.sv
module tbrx_handshake
    import tbrx_pkg::*;
#(
    parameter int SYNC_TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic data_in,
    input  logic clk_in,
    input  logic xfer_done,
    output logic clk_pull,
    output logic sync_go,
    output logic recv_active,
    output logic sync_err,
    output logic busy
);
    localparam int TMR_W = $clog2(SYNC_TIMEOUT + 1);

    hs_state_t        state, state_nx;
    logic [TMR_W-1:0] timer;
    logic             waiting, expire;

    assign waiting     = (state == HS_WAIT_LO) || (state == HS_WAIT_HI);
    assign sync_go     = (state == HS_WAIT_HI) && data_in && clk_in;
    assign expire      = waiting && !sync_go && (timer == TMR_W'(SYNC_TIMEOUT - 1));
    assign clk_pull    = (state == HS_ACK);
    assign recv_active = (state == HS_RECV);
    assign busy        = (state != HS_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE:    if (!data_in) state_nx = HS_ACK;
            HS_ACK:     if (data_in)  state_nx = HS_WAIT_LO;
            HS_WAIT_LO: if (!data_in && !clk_in) state_nx = HS_WAIT_HI;
            HS_WAIT_HI: if (sync_go) state_nx = HS_RECV;
            HS_RECV:    if (xfer_done) state_nx = HS_IDLE;
            default:    state_nx = HS_IDLE;
        endcase
        if (expire) state_nx = HS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HS_IDLE;
            timer    <= '0;
            sync_err <= 1'b0;
        end else begin
            state    <= state_nx;
            sync_err <= expire;
            if (state == HS_ACK) timer <= '0;
            else if (waiting)    timer <= timer + 1'b1;
        end
    end

    // R1: acknowledge only after DATA was seen low
    a_r1_ack_after_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_pull) |-> $past(!data_in));
    // R2: CLOCK released only after DATA was seen high
    a_r2_release_after_data: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_pull) |-> $past(data_in));
    // R3: never drive while receiving
    a_r3_quiet_in_recv: assert property (@(posedge clk) disable iff (rst)
        recv_active |-> !clk_pull);
    // R9: error is a single pulse and leaves the block idle
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        sync_err |-> (!busy && $past(busy)));
    a_r9_err_single: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !sync_err);

endmodule

// File: rtl/tbrx_sched.sv
module tbrx_sched
    import tbrx_pkg::*;
#(
    parameter int FIRST_OFS = 4,
    parameter int PAIR_GAP  = 8,
    parameter int BYTE_GAP  = 22
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  run,
    output logic                  take,
    output logic [PAIR_IDX_W-1:0] pair_idx
);
    localparam int MAXG = max3(FIRST_OFS, PAIR_GAP, BYTE_GAP);
    localparam int CW   = $clog2(MAXG + 1);

    logic [CW-1:0] cnt;
    logic          last_pair;

    assign take      = run && (cnt == '0);
    assign last_pair = (pair_idx == PAIR_IDX_W'(PAIRS_PER_BYTE - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pair_idx <= '0;
        end else if (start) begin
            cnt      <= CW'(FIRST_OFS - 1);
            pair_idx <= '0;
        end else if (run) begin
            if (take) begin
                cnt      <= last_pair ? CW'(BYTE_GAP - 1) : CW'(PAIR_GAP - 1);
                pair_idx <= pair_idx + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R4: samples never fall on adjacent edges when the spacing exceeds one
    a_r4_take_spaced: assert property (@(posedge clk) disable iff (rst)
        (take && (PAIR_GAP > 1) && (BYTE_GAP > 1)) |=> !take);
    // R4: a fresh start always points at the first pair
    a_r4_start_first_pair: assert property (@(posedge clk) disable iff (rst)
        start |=> (pair_idx == '0));

endmodule

// File: rtl/tbrx_assemble.sv
module tbrx_assemble
    import tbrx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  take,
    input  logic [PAIR_IDX_W-1:0] pair_idx,
    input  logic                  data_in,
    input  logic                  clk_in,
    input  logic [CNT_W-1:0]      byte_total,
    output logic [7:0]            rx_byte,
    output logic                  rx_valid,
    output logic [CNT_W-1:0]      rx_index,
    output logic                  xfer_done
);
    line_pair_t       pr;
    logic [7:0]       sh, shifted;
    logic [CNT_W-1:0] idx, last_idx;
    logic             byte_end;

    assign pr.hi     = data_in;
    assign pr.lo     = clk_in;
    assign shifted   = {pr, sh[7:2]};
    assign byte_end  = take && (pair_idx == PAIR_IDX_W'(PAIRS_PER_BYTE - 1));
    assign xfer_done = byte_end && (idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_index <= '0;
            idx      <= '0;
            last_idx <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (start) begin
                idx      <= '0;
                last_idx <= (byte_total == '0) ? '0 : byte_total - 1'b1;
            end
            if (take) sh <= shifted;
            if (byte_end) begin
                rx_byte  <= unshuffle(shifted);
                rx_valid <= 1'b1;
                rx_index <= idx;
                idx      <= idx + 1'b1;
            end
        end
    end

    // R7: strobe lasts one cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    // R7: consecutive strobes of one transfer carry consecutive indices
    a_r7_index_step: assert property (@(posedge clk) disable iff (rst)
        (byte_end && !xfer_done) |=> (idx == rx_index + 1'b1));

endmodule

// File: rtl/twobit_rx.sv
module twobit_rx
    import tbrx_pkg::*;
#(
    parameter int FIRST_OFS    = 4,
    parameter int PAIR_GAP     = 8,
    parameter int BYTE_GAP     = 22,
    parameter int SYNC_TIMEOUT = 256,
    parameter int CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_in,
    input  logic             clk_in,
    input  logic [CNT_W-1:0] byte_total,
    output logic             clk_pull,
    output logic             busy,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic [CNT_W-1:0] rx_index,
    output logic             sync_err
);
    logic                  sync_go, recv_active, take, xfer_done;
    logic [PAIR_IDX_W-1:0] pair_idx;

    tbrx_handshake #(.SYNC_TIMEOUT(SYNC_TIMEOUT)) u_hs (
        .clk(clk), .rst(rst), .data_in(data_in), .clk_in(clk_in),
        .xfer_done(xfer_done), .clk_pull(clk_pull), .sync_go(sync_go),
        .recv_active(recv_active), .sync_err(sync_err), .busy(busy)
    );

    tbrx_sched #(.FIRST_OFS(FIRST_OFS), .PAIR_GAP(PAIR_GAP), .BYTE_GAP(BYTE_GAP)) u_sch (
        .clk(clk), .rst(rst), .start(sync_go), .run(recv_active),
        .take(take), .pair_idx(pair_idx)
    );

    tbrx_assemble #(.CNT_W(CNT_W)) u_asm (
        .clk(clk), .rst(rst), .start(sync_go), .take(take), .pair_idx(pair_idx),
        .data_in(data_in), .clk_in(clk_in), .byte_total(byte_total),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_index(rx_index),
        .xfer_done(xfer_done)
    );

    // R8: the final strobe coincides with idle
    a_r8_idle_with_last: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && recv_active) |=> (rx_valid && !busy));
    // R10: a strobe is never seen while the handshake is still open
    a_r10_no_strobe_in_ack: assert property (@(posedge clk) disable iff (rst)
        clk_pull |-> !rx_valid);

endmodule

// File: tb/sim_twobit_rx.sv
module sim_twobit_rx;
    localparam int F   = 4;
    localparam int PG  = 8;
    localparam int BG  = 22;
    localparam int TO  = 64;
    localparam int CW  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dev_d = 1'b1;
    logic          dev_c = 1'b1;
    logic [CW-1:0] byte_total = '0;
    logic          data_in, clk_in, clk_pull, busy, rx_valid, sync_err;
    logic [7:0]    rx_byte;
    logic [CW-1:0] rx_index;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    logic [7:0] bytes [16];

    always #4 clk = ~clk;

    assign data_in = dev_d;
    assign clk_in  = dev_c & ~clk_pull;

    twobit_rx #(.FIRST_OFS(F), .PAIR_GAP(PG), .BYTE_GAP(BG),
                .SYNC_TIMEOUT(TO), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .data_in(data_in), .clk_in(clk_in),
        .byte_total(byte_total), .clk_pull(clk_pull), .busy(busy),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_index(rx_index),
        .sync_err(sync_err)
    );

    always @(negedge clk) if (!rst && rx_valid) vcount++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // pair k of natural byte b, upper bit on DATA
    function automatic logic [1:0] pair_of(input logic [7:0] b, input int k);
        case (k)
            0: return {b[3], b[1]};
            1: return {b[2], b[0]};
            2: return {b[7], b[5]};
            default: return {b[6], b[4]};
        endcase
    endfunction

    // Called at a negedge where clk_pull has just been seen high.
    task automatic hs_finish(input int hold);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(clk_pull == 1'b1, "R2", "clk_pull held", clk_pull, 1);
        end
        chk(busy == 1'b1, "R10", "busy in ack", busy, 1);
        dev_d = 1'b1;
        @(negedge clk);
        chk(clk_pull == 1'b0, "R2", "clk_pull released", clk_pull, 0);
    endtask

    // Called at a negedge in idle.
    task automatic handshake(input int hold);
        dev_d = 1'b0;
        @(negedge clk);
        chk(clk_pull == 1'b1, "R1", "ack one cycle later", clk_pull, 1);
        hs_finish(hold);
    endtask

    // Ends just after the reference edge.
    task automatic sync_pulse(input bit noise);
        if (noise) begin
            dev_d = 1'b0;
            repeat (2) @(negedge clk);
            dev_d = 1'b1;
            dev_c = 1'b0;
            repeat (2) @(negedge clk);
            dev_c = 1'b1;
            @(negedge clk);
            chk(clk_pull == 1'b0 && busy == 1'b1, "R3", "single-line noise ignored",
                {clk_pull, busy}, 1);
        end
        dev_d = 1'b0;
        dev_c = 1'b0;
        repeat (2) @(negedge clk);
        dev_d = 1'b1;
        dev_c = 1'b1;
        @(posedge clk);
    endtask

    task automatic send_bytes(input int n, input bit hold_low);
        int gap;
        logic [1:0] pv;
        gap = F;
        for (int b = 0; b < n; b++) begin
            for (int p = 0; p < 4; p++) begin
                pv = pair_of(bytes[b], p);
                repeat (gap - 1) @(posedge clk);
                @(negedge clk);
                dev_d = pv[1];
                dev_c = pv[0];
                @(posedge clk);
                @(negedge clk);
                chk(clk_pull == 1'b0, "R3", "no drive while receiving", clk_pull, 0);
                if (p < 3) begin
                    dev_d = ~pv[1];
                    dev_c = ~pv[0];
                    chk(rx_valid == 1'b0, "R7", "no strobe mid-byte", rx_valid, 0);
                    gap = PG;
                end else begin
                    chk(rx_valid == 1'b1, "R7", "strobe after fourth sample", rx_valid, 1);
                    chk(rx_byte == bytes[b], (b == 0) ? "R4" : "R6", "rx_byte",
                        rx_byte, bytes[b]);
                    chk(rx_byte == bytes[b], "R5", "bit order", rx_byte, bytes[b]);
                    chk(rx_index == CW'(b), "R7", "rx_index", rx_index, b);
                    if (b == n - 1) begin
                        chk(busy == 1'b0, "R8", "idle with last strobe", busy, 0);
                        dev_d = hold_low ? 1'b0 : 1'b1;
                        dev_c = 1'b1;
                    end else begin
                        chk(busy == 1'b1, "R10", "busy between bytes", busy, 1);
                        dev_d = ~pv[1];
                        dev_c = ~pv[0];
                    end
                    gap = BG;
                end
            end
        end
    endtask

    task automatic transfer(input int total, input int n, input bit noise,
                            input bit hold_low);
        int v0;
        byte_total = CW'(total);
        for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
        v0 = vcount;
        sync_pulse(noise);
        send_bytes(n, hold_low);
        @(negedge clk);
        chk(vcount - v0 == n, "R7", "strobe count", vcount - v0, n);
        if (hold_low) begin
            chk(clk_pull == 1'b1, "R8", "ack right after last byte", clk_pull, 1);
        end else begin
            chk(busy == 1'b0 && clk_pull == 1'b0, "R10", "idle after transfer",
                {busy, clk_pull}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h2b17));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(clk_pull == 1'b0, "R1", "reset clk_pull", clk_pull, 0);
        chk(busy == 1'b0, "R10", "reset busy", busy, 0);
        chk(rx_valid == 1'b0, "R7", "reset rx_valid", rx_valid, 0);
        chk(sync_err == 1'b0, "R9", "reset sync_err", sync_err, 0);

        // directed: one byte, count of one
        bytes[0] = 8'hA5;
        handshake(0);
        byte_total = 8'd1;
        begin : d1
            int v0;
            v0 = vcount;
            sync_pulse(1'b0);
            send_bytes(1, 1'b0);
            @(negedge clk);
            chk(vcount - v0 == 1, "R8", "single byte", vcount - v0, 1);
        end

        // directed: count of zero acts as one
        repeat (3) @(negedge clk);
        handshake(2);
        transfer(0, 1, 1'b0, 1'b0);

        // random transfers with noise and varied ack holding
        for (int t = 0; t < 6; t++) begin
            int n;
            n = 1 + int'($urandom % 5);
            repeat (1 + int'($urandom % 4)) @(negedge clk);
            handshake(int'($urandom % 4));
            transfer(n, n, bit'($urandom % 2), 1'b0);
        end

        // corner: DATA held low right after the last byte
        repeat (2) @(negedge clk);
        handshake(1);
        transfer(3, 3, 1'b1, 1'b1);
        hs_finish(0);
        transfer(2, 2, 1'b0, 1'b0);

        // sync timeout
        repeat (2) @(negedge clk);
        handshake(0);
        begin : to_chk
            int k;
            k = 0;
            while (!sync_err && k < TO + 10) begin
                @(negedge clk);
                k++;
            end
            chk(k == TO, "R9", "timeout cycle", k, TO);
            chk(busy == 1'b0, "R9", "idle at error", busy, 0);
            @(negedge clk);
            chk(sync_err == 1'b0, "R9", "error is one pulse", sync_err, 0);
        end

        // recovery after timeout
        handshake(0);
        transfer(4, 4, 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule